// File: doc/BRIEF.md
# Program Sequencer for a 4-bit Controller

This block is the instruction fetch and control-flow engine of a small 4-bit controller core. Each machine cycle it puts a 14-bit program address on `pc_o` and takes one instruction word back from program memory. Only the low 10 bits of each word are used. The opcode is decoded as it arrives. Some opcodes are followed by a parameter word, and the sequencer fetches that word in the next cycle. For all other opcodes it forms a data-memory address from the W, X and Y pointer registers.

The sequencer owns the status flag and decides every change of flow: short branches within a 256-word page, long jumps, long branches and long calls across the whole program space, short calls into the low 64 words, table branches built from the A and B registers, and returns. Every conditional transfer tests the status flag. A transfer that is not taken sets the flag back to 1. Calls raise a push request that carries the return address, and a return raises a pop request and takes its new address from the stack that same cycle. The arithmetic unit and the stack storage sit outside the block. A free-running machine-cycle counter and an opcode-fetch marker make the cost of each instruction visible.

Top module: `prog_sequencer`

## Requirements
- R1: The program address advances by one, modulo 2^14, for every instruction word fetched, and bits 15..10 of a fetched word never affect the behaviour.
- R2: Opcodes 0x100–0x13F and 0x150–0x1AF take two words and two cycles, with the second word as parameter. 0x140–0x14F, 0x1B0 and every other opcode take one word.
- R3: For a two-word opcode `ram_addr_o` is the 10-bit parameter word. Otherwise it is {W[1:0], X[3:0], Y[3:0]}.
- R4: Short branch (0x300–0x3FF): with status 1, address bits 7..0 become opcode bits 7..0, and the upper bits come from the incremented address.
- R5: Long jump (0x150–0x15F) is unconditional and leaves status unchanged. The new address is {opcode[3:0], parameter[9:0]}.
- R6: Long call (0x160–0x16F) and long branch (0x170–0x17F) jump like R5 when status is 1. The long call also pushes the address of the word after the parameter.
- R7: Short call (0x1C0–0x1FF): with status 1 it pushes the address after the opcode, jumps to {0, opcode[5:0]}, and costs one extra cycle (two in total).
- R8: Any conditional transfer whose status is 0 sets status to 1, continues at the next word, pushes nothing, and costs only its fetch cycles. This holds even when a status write arrives in the same cycle.
- R9: Table branch (0x0B0–0x0BF) jumps to {0, opcode[3:0], B, A} in one cycle.
- R10: Return (0x010) raises `pop_o` in its fetch cycle, loads `pop_pc_i`, and costs two extra cycles (three in total).
- R11: Reset sets the address to 0, status to 1 and the cycle counter to 0, and the next cycle is an opcode fetch.
- R12: `cycle_cnt_o` increases by one each clock after reset. `fetch_o` marks each opcode fetch cycle.
- R13: An opcode of no listed class only advances the address by one, in one cycle.
- R14: `st_we_i` loads `st_wd_i` into the status flag, except where R8 forces it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Program word at `pc_o` |
| pc_o | output | 14 | Program address |
| fetch_o | output | 1 | Cycle fetches an opcode |
| reg_a_i | input | 4 | Accumulator value |
| reg_b_i | input | 4 | B register value |
| reg_w_i | input | 2 | W pointer value |
| reg_x_i | input | 4 | X pointer value |
| reg_y_i | input | 4 | Y pointer value |
| st_we_i | input | 1 | Status write enable from the ALU |
| st_wd_i | input | 1 | Status write value |
| st_o | output | 1 | Status flag |
| op_o | output | 10 | Latched opcode |
| exec_o | output | 1 | Latched instruction is complete this cycle |
| ram_addr_o | output | 10 | Data-memory address |
| push_o | output | 1 | Stack push request |
| push_pc_o | output | 14 | Return address to push |
| pop_o | output | 1 | Stack pop request |
| pop_pc_i | input | 14 | Return address from the stack |
| cycle_cnt_o | output | 32 | Machine-cycle counter |

## Verification
A wrong phase state shows at the next opcode fetch. `fetch_o` rises a cycle early or late, and `pc_o` then points at a parameter word or skips one. A stale status flag changes whether the very next conditional transfer is taken, so `pc_o` and the stack request are wrong in the cycle after that opcode. A corrupted latched opcode or parameter shows in the address loaded at the end of the second word, and on `ram_addr_o` in the cycle right after.

// File: rtl/seq_pkg.sv
package seq_pkg;
   // field widths inside an opcode word
   localparam int BR_FIELD_W  = 8;
   localparam int CAL_FIELD_W = 6;

   typedef enum logic [3:0] {
      C_NOP, C_BR, C_CAL, C_TBR, C_RTN, C_JMPL, C_CALL, C_BRL, C_DDATA
   } op_cls_e;

   typedef enum logic [1:0] {
      S_OP, S_PARAM, S_WAIT
   } seq_state_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
#(
   parameter int OP_W = 10
) (
   input  logic [OP_W-1:0] word_i,
   output op_cls_e         cls_o,
   output logic            dual_o
);
   always_comb begin
      dual_o = ((word_i >= 10'h100) && (word_i < 10'h140)) ||
               ((word_i >= 10'h150) && (word_i < 10'h1B0));
      if (word_i[9:8] == 2'b11)            cls_o = C_BR;
      else if (word_i[9:6] == 4'b0111)     cls_o = C_CAL;
      else if (word_i[9:4] == 6'h0B)       cls_o = C_TBR;
      else if (word_i == 10'h010)          cls_o = C_RTN;
      else if (word_i[9:4] == 6'h15)       cls_o = C_JMPL;
      else if (word_i[9:4] == 6'h16)       cls_o = C_CALL;
      else if (word_i[9:4] == 6'h17)       cls_o = C_BRL;
      else if (dual_o)                     cls_o = C_DDATA;
      else                                 cls_o = C_NOP;
   end
endmodule

// File: rtl/seq_target.sv
module seq_target
   import seq_pkg::*;
#(
   parameter int PC_W  = 14,
   parameter int OP_W  = 10,
   parameter int NIB_W = 4
) (
   input  logic [PC_W-BR_FIELD_W-1:0] pc_hi_i,
   input  logic [BR_FIELD_W-1:0]      word_lo_i,
   input  logic [NIB_W-1:0]           long_nib_i,
   input  logic [OP_W-1:0]            param_i,
   input  logic [NIB_W-1:0]           a_i,
   input  logic [NIB_W-1:0]           b_i,
   output logic [PC_W-1:0]            br_tgt_o,
   output logic [PC_W-1:0]            cal_tgt_o,
   output logic [PC_W-1:0]            tbr_tgt_o,
   output logic [PC_W-1:0]            long_tgt_o
);
   localparam int TBR_W = 3 * NIB_W;

   assign br_tgt_o   = {pc_hi_i, word_lo_i};
   assign cal_tgt_o  = {{(PC_W-CAL_FIELD_W){1'b0}}, word_lo_i[CAL_FIELD_W-1:0]};
   assign long_tgt_o = {long_nib_i, param_i};

   generate
      if (PC_W > TBR_W) begin : g_tbr_pad
         assign tbr_tgt_o = {{(PC_W-TBR_W){1'b0}}, word_lo_i[NIB_W-1:0], b_i, a_i};
      end else begin : g_tbr_cut
         logic [TBR_W-1:0] tbr_full;
         assign tbr_full  = {word_lo_i[NIB_W-1:0], b_i, a_i};
         assign tbr_tgt_o = tbr_full[PC_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/seq_cycle_ctr.sv
module seq_cycle_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (rst) cnt_o <= '0;
      else     cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
   import seq_pkg::*;
#(
   parameter int PC_W      = 14,
   parameter int OP_W      = 10,
   parameter int WORD_W    = 16,
   parameter int NIB_W     = 4,
   parameter int WPTR_W    = 2,
   parameter int CNT_W     = 32,
   parameter int CAL_EXTRA = 1,
   parameter int RTN_EXTRA = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] instr_i,
   output logic [PC_W-1:0]   pc_o,
   output logic              fetch_o,
   input  logic [NIB_W-1:0]  reg_a_i,
   input  logic [NIB_W-1:0]  reg_b_i,
   input  logic [WPTR_W-1:0] reg_w_i,
   input  logic [NIB_W-1:0]  reg_x_i,
   input  logic [NIB_W-1:0]  reg_y_i,
   input  logic              st_we_i,
   input  logic              st_wd_i,
   output logic              st_o,
   output logic [OP_W-1:0]   op_o,
   output logic              exec_o,
   output logic [OP_W-1:0]   ram_addr_o,
   output logic              push_o,
   output logic [PC_W-1:0]   push_pc_o,
   output logic              pop_o,
   input  logic [PC_W-1:0]   pop_pc_i,
   output logic [CNT_W-1:0]  cycle_cnt_o
);
   localparam int WAIT_MAX = (CAL_EXTRA > RTN_EXTRA) ? CAL_EXTRA : RTN_EXTRA;
   localparam int WAIT_W   = $clog2(WAIT_MAX + 1) + 1;

   generate
      if (PC_W != NIB_W + OP_W) begin : g_bad_pc
         $error("program address width must hold nibble plus parameter word");
      end
      if (OP_W != 10) begin : g_bad_op
         $error("opcode decode assumes a 10-bit opcode");
      end
      if (WPTR_W + 2 * NIB_W != OP_W) begin : g_bad_ptr
         $error("W:X:Y must form an opcode-wide RAM address");
      end
      if (WORD_W < OP_W) begin : g_bad_word
         $error("program word narrower than opcode");
      end
      if (CAL_EXTRA < 0 || RTN_EXTRA < 0) begin : g_bad_extra
         $error("extra cycle counts must be non-negative");
      end
   endgenerate

   seq_state_e          state_q, state_n;
   logic [PC_W-1:0]     pc_q, pc_n, pc_inc;
   logic [WAIT_W-1:0]   wait_q, wait_n;
   logic                st_q, st_set;
   logic [OP_W-1:0]     word, op_q, param_q;
   op_cls_e             cls_w, cls_q;
   logic                dual_w, dual_q;
   logic                push, pop, done, exec_q;
   logic                in_param;
   logic [PC_W-1:0]     br_tgt, cal_tgt, tbr_tgt, long_tgt;
   logic                unused_hi;

   assign word      = instr_i[OP_W-1:0];
   assign unused_hi = ^instr_i;
   assign pc_inc    = pc_q + 1'b1;
   assign in_param  = (state_q == S_PARAM);

   seq_decode #(.OP_W(OP_W)) u_dec (
      .word_i (word),
      .cls_o  (cls_w),
      .dual_o (dual_w)
   );

   seq_target #(.PC_W(PC_W), .OP_W(OP_W), .NIB_W(NIB_W)) u_tgt (
      .pc_hi_i    (pc_inc[PC_W-1:BR_FIELD_W]),
      .word_lo_i  (word[BR_FIELD_W-1:0]),
      .long_nib_i (op_q[NIB_W-1:0]),
      .param_i    (word),
      .a_i        (reg_a_i),
      .b_i        (reg_b_i),
      .br_tgt_o   (br_tgt),
      .cal_tgt_o  (cal_tgt),
      .tbr_tgt_o  (tbr_tgt),
      .long_tgt_o (long_tgt)
   );

   seq_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .cnt_o (cycle_cnt_o)
   );

   always_comb begin
      pc_n    = pc_q;
      state_n = state_q;
      wait_n  = wait_q;
      st_set  = 1'b0;
      push    = 1'b0;
      pop     = 1'b0;
      done    = 1'b0;
      case (state_q)
         S_OP: begin
            pc_n = pc_inc;
            if (dual_w) begin
               state_n = S_PARAM;
            end else begin
               done = 1'b1;
               case (cls_w)
                  C_BR: begin
                     if (st_q) pc_n = br_tgt;
                     else      st_set = 1'b1;
                  end
                  C_CAL: begin
                     if (st_q) begin
                        push = 1'b1;
                        pc_n = cal_tgt;
                        if (CAL_EXTRA > 0) begin
                           state_n = S_WAIT;
                           wait_n  = WAIT_W'(CAL_EXTRA);
                        end
                     end else begin
                        st_set = 1'b1;
                     end
                  end
                  C_TBR: pc_n = tbr_tgt;
                  C_RTN: begin
                     pop  = 1'b1;
                     pc_n = pop_pc_i;
                     if (RTN_EXTRA > 0) begin
                        state_n = S_WAIT;
                        wait_n  = WAIT_W'(RTN_EXTRA);
                     end
                  end
                  default: ;
               endcase
            end
         end
         S_PARAM: begin
            pc_n    = pc_inc;
            done    = 1'b1;
            state_n = S_OP;
            case (cls_q)
               C_JMPL: pc_n = long_tgt;
               C_CALL, C_BRL: begin
                  if (st_q) begin
                     pc_n = long_tgt;
                     push = (cls_q == C_CALL);
                  end else begin
                     st_set = 1'b1;
                  end
               end
               default: ;
            endcase
         end
         S_WAIT: begin
            if (wait_q <= WAIT_W'(1)) state_n = S_OP;
            else                      wait_n  = wait_q - 1'b1;
         end
         default: state_n = S_OP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         state_q <= S_OP;
         wait_q  <= '0;
         st_q    <= 1'b1;
         op_q    <= '0;
         param_q <= '0;
         cls_q   <= C_NOP;
         dual_q  <= 1'b0;
         exec_q  <= 1'b0;
      end else begin
         pc_q    <= pc_n;
         state_q <= state_n;
         wait_q  <= wait_n;
         exec_q  <= done;
         if (st_set)       st_q <= 1'b1;
         else if (st_we_i) st_q <= st_wd_i;
         if (state_q == S_OP) begin
            op_q   <= word;
            cls_q  <= cls_w;
            dual_q <= dual_w;
         end
         if (state_q == S_PARAM) param_q <= word;
      end
   end

   assign pc_o       = pc_q;
   assign fetch_o    = (state_q == S_OP);
   assign st_o       = st_q;
   assign op_o       = op_q;
   assign exec_o     = exec_q;
   assign ram_addr_o = dual_q ? param_q : {reg_w_i, reg_x_i, reg_y_i};
   assign push_o     = push;
   assign push_pc_o  = pc_inc;
   assign pop_o      = pop;
endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
   parameter int PC_W  = 14,
   parameter int OP_W  = 10,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             fetch_o,
   input logic             in_param,
   input logic             st_o,
   input logic             push_o,
   input logic             pop_o,
   input logic [PC_W-1:0]  pc_o,
   input logic [OP_W-1:0]  instr_lo,
   input logic [OP_W-1:0]  op_o,
   input logic [CNT_W-1:0] cycle_cnt_o
);
   // R13
   nop_step_chk: assert property (@(posedge clk) disable iff (rst)
      (fetch_o && instr_lo == '0) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

   // R4
   br_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (fetch_o && st_o && instr_lo[9:8] == 2'b11) |=> pc_o[7:0] == $past(instr_lo[7:0]));

   // R8
   br_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (fetch_o && !st_o && instr_lo[9:8] == 2'b11) |=> st_o);

   // R5
   jmpl_tgt_chk: assert property (@(posedge clk) disable iff (rst)
      (in_param && op_o[9:4] == 6'h15) |=> pc_o == {$past(op_o[3:0]), $past(instr_lo)});

   // R7
   push_st_chk: assert property (@(posedge clk) disable iff (rst)
      push_o |-> st_o);

   // R10
   ret_gap_chk: assert property (@(posedge clk) disable iff (rst)
      pop_o |=> !fetch_o ##1 !fetch_o ##1 fetch_o);

   // R12
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> cycle_cnt_o == CNT_W'($past(cycle_cnt_o) + 1'b1));

   // R6
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(push_o && pop_o));
endmodule

bind prog_sequencer prog_sequencer_chk #(.PC_W(PC_W), .OP_W(OP_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .fetch_o     (fetch_o),
   .in_param    (in_param),
   .st_o        (st_o),
   .push_o      (push_o),
   .pop_o       (pop_o),
   .pc_o        (pc_o),
   .instr_lo    (instr_i[OP_W-1:0]),
   .op_o        (op_o),
   .cycle_cnt_o (cycle_cnt_o)
);

// File: tb/prog_sequencer_tb.sv
`timescale 1ns/1ps
module prog_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr;
   logic [13:0] pc;
   logic        fetch;
   logic [3:0]  ra = 4'h0, rb = 4'h0;
   logic [1:0]  rw = 2'h2;
   logic [3:0]  rx = 4'h3, ry = 4'h4;
   logic        st_we = 1'b0, st_wd = 1'b0;
   logic        st;
   logic [9:0]  op;
   logic        exec;
   logic [9:0]  ram_addr;
   logic        push, pop;
   logic [13:0] push_pc;
   logic [13:0] pop_pc = 14'h0;
   logic [31:0] cyc_cnt;
   logic [15:0] mem [256];
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   assign instr = mem[pc[7:0]];

   prog_sequencer u_dut (
      .clk(clk), .rst(rst), .instr_i(instr), .pc_o(pc), .fetch_o(fetch),
      .reg_a_i(ra), .reg_b_i(rb), .reg_w_i(rw), .reg_x_i(rx), .reg_y_i(ry),
      .st_we_i(st_we), .st_wd_i(st_wd), .st_o(st), .op_o(op), .exec_o(exec),
      .ram_addr_o(ram_addr), .push_o(push), .push_pc_o(push_pc), .pop_o(pop),
      .pop_pc_i(pop_pc), .cycle_cnt_o(cyc_cnt)
   );

   typedef struct packed {
      logic [15:0] word;
      logic [15:0] prm;
      logic        st0;
      logic [3:0]  a;
      logic [3:0]  b;
      logic [13:0] popv;
      logic [13:0] epc;
      logic        est;
      logic [1:0]  ecyc;
      logic        epush;
      logic [13:0] eppc;
      logic        epop;
      logic [9:0]  eram;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{16'h0000, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0002, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R13 plain
      '{16'hFF55, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0055, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R1 high bits ignored
      '{16'h03A7, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h0,    14'h00A7, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R4 taken
      '{16'h03A7, 16'h0000, 1'b0, 4'h0, 4'h0, 14'h0,    14'h0002, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R8 short
      '{16'h015B, 16'hAEC4, 1'b0, 4'h0, 4'h0, 14'h0,    14'h2EC4, 1'b0, 2'd2, 1'b0, 14'h0, 1'b0, 10'h2C4}, // R5
      '{16'h0173, 16'h0011, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0C11, 1'b1, 2'd2, 1'b0, 14'h0, 1'b0, 10'h011}, // R6 branch
      '{16'h0173, 16'h0011, 1'b0, 4'h0, 4'h0, 14'h0,    14'h0003, 1'b1, 2'd2, 1'b0, 14'h0, 1'b0, 10'h011}, // R8 long branch
      '{16'h016F, 16'h03FF, 1'b1, 4'h0, 4'h0, 14'h0,    14'h3FFF, 1'b1, 2'd2, 1'b1, 14'h3, 1'b0, 10'h3FF}, // R6 call
      '{16'h016F, 16'h03FF, 1'b0, 4'h0, 4'h0, 14'h0,    14'h0003, 1'b1, 2'd2, 1'b0, 14'h0, 1'b0, 10'h3FF}, // R8 long call
      '{16'h01E9, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0029, 1'b1, 2'd2, 1'b1, 14'h2, 1'b0, 10'h234}, // R7
      '{16'h01E9, 16'h0000, 1'b0, 4'h0, 4'h0, 14'h0,    14'h0002, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R8 short call
      '{16'h00B7, 16'h0000, 1'b0, 4'hC, 4'h5, 14'h0,    14'h075C, 1'b0, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R9
      '{16'h0010, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h1234, 14'h1234, 1'b1, 2'd3, 1'b0, 14'h0, 1'b1, 10'h234}, // R10
      '{16'h0120, 16'h0155, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0003, 1'b1, 2'd2, 1'b0, 14'h0, 1'b0, 10'h155}, // R2 R3 data
      '{16'h0140, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0002, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}, // R2 gap
      '{16'h01AF, 16'h0001, 1'b0, 4'h0, 4'h0, 14'h0,    14'h0003, 1'b0, 2'd2, 1'b0, 14'h0, 1'b0, 10'h001}, // R2 top edge
      '{16'h01B0, 16'h0000, 1'b1, 4'h0, 4'h0, 14'h0,    14'h0002, 1'b1, 2'd1, 1'b0, 14'h0, 1'b0, 10'h234}  // R2 above range
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_prog(input logic [15:0] w, input logic [15:0] p);
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      mem[1] = w;
      mem[2] = p;
   endtask

   // reset, then run the NOP at address 0 with a status write of st0
   task automatic start(input logic st0);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      st_we = 1'b1;
      st_wd = st0;
      @(negedge clk);
      st_we = 1'b0;
   endtask

   task automatic run_vec(input int k);
      vec_t v;
      int cyc;
      logic saw_push, saw_pop;
      logic [13:0] ppc;
      logic [31:0] c0;
      v = VECS[k];
      load_prog(v.word, v.prm);
      ra = v.a; rb = v.b; pop_pc = v.popv;
      start(v.st0);
      chk($sformatf("R14 st write v%0d", k), {31'b0, st}, {31'b0, v.st0});
      chk($sformatf("R13 exec after nop v%0d", k), {31'b0, exec}, 32'd1);
      cyc = 0; saw_push = 1'b0; saw_pop = 1'b0; ppc = '0; c0 = cyc_cnt;
      do begin
         if (push) begin saw_push = 1'b1; ppc = push_pc; end
         if (pop) saw_pop = 1'b1;
         @(negedge clk);
         cyc++;
      end while (!fetch && cyc < 8);
      chk($sformatf("R1/flow pc v%0d", k), {18'b0, pc}, {18'b0, v.epc});
      chk($sformatf("R8 status v%0d", k), {31'b0, st}, {31'b0, v.est});
      chk($sformatf("R2 cycles v%0d", k), cyc, {30'b0, v.ecyc});
      chk($sformatf("R12 counter v%0d", k), cyc_cnt - c0, {30'b0, v.ecyc});
      chk($sformatf("R6 push v%0d", k), {31'b0, saw_push}, {31'b0, v.epush});
      if (v.epush) chk($sformatf("R7 push addr v%0d", k), {18'b0, ppc}, {18'b0, v.eppc});
      chk($sformatf("R10 pop v%0d", k), {31'b0, saw_pop}, {31'b0, v.epop});
      chk($sformatf("R3 ram addr v%0d", k), {22'b0, ram_addr}, {22'b0, v.eram});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      load_prog(16'h0000, 16'h0000);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      // R11 reset state
      chk("R11 pc", {18'b0, pc}, 32'd0);
      chk("R11 status", {31'b0, st}, 32'd1);
      chk("R11 counter", cyc_cnt, 32'd0);
      chk("R11 fetch", {31'b0, fetch}, 32'd1);
      chk("R11 no push/pop", {30'b0, push, pop}, 32'd0);

      for (int k = 0; k < NV; k++) run_vec(k);

      // R1 wrap at the top of the program space
      load_prog(16'h015F, 16'h03FF);
      start(1'b1);
      @(negedge clk);
      @(negedge clk);
      chk("R5 jump to top", {18'b0, pc}, 32'h3FFF);
      @(negedge clk);
      chk("R1 wrap to zero", {18'b0, pc}, 32'd0);

      // R8 re-arm wins over a same-cycle status write of 0
      load_prog(16'h03A7, 16'h0000);
      start(1'b0);
      st_we = 1'b1; st_wd = 1'b0;
      @(negedge clk);
      st_we = 1'b0;
      chk("R8 rearm priority", {31'b0, st}, 32'd1);
      chk("R8 rearm pc", {18'b0, pc}, 32'd2);

      // R14 status write while a plain opcode runs
      load_prog(16'h0000, 16'h0000);
      start(1'b1);
      st_we = 1'b1; st_wd = 1'b0;
      @(negedge clk);
      st_we = 1'b0;
      chk("R14 write under nop", {31'b0, st}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule